// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block guards a programmable clock generator against a frequency setting that leaves the system unstable. When armed, it counts coarse time ticks from a prescaler. In hardware each tick is about 290 ms, and the prescaler divide value is a parameter, so a bench can use a short tick. If no configuration write restarts the count before the programmed number of ticks has passed, the block raises a sticky alarm flag. It then overrides the operating frequency-select code with a stored safe code and drives an active-low system reset for a fixed number of clocks.

The block also chooses the frequency-select code that the synthesizer uses. Outside the alarm state the code comes from one of two places. The first is the four strap inputs latched at power-up, widened with a zero in the top bit. The second is the five code bits of the frequency-select register. While the alarm is set, the safe code from the watchdog control register takes the place of both. A separate output tells the synthesizer whether it should take its dividers from the direct divider registers or from the selected code. The alarm forces that output back to the code path.

Software clears the alarm by writing the control register with its status bit at 0. That write also restarts the timing.

Top module: `ocwd_top`

## Requirements
- R1: After reset `wd_alarm` is 0, `sys_rst_n` is 1 and the tick count is cleared.
- R2: With `wd_ctrl[6]`=1, the alarm sets exactly `N`×`TICK_DIV` clock edges after the edge that captured the last restart. `N` is `wd_limit`, and a limit of 0 counts as 1.
- R3: While `wd_ctrl[6]`=0 the count is held at zero, and no alarm or reset pulse occurs however long the wait.
- R4: A one-cycle pulse on `cfg_wr` or `ctrl_wr` restarts the timeout from zero, so the alarm cycle is measured from the latest pulse.
- R5: `sys_rst_n` goes low on the same edge that sets the alarm. It stays low for exactly `RST_CYCLES` cycles and then returns high.
- R6: The alarm stays set until a `ctrl_wr` pulse with `wd_ctrl[5]`=0. A write with `wd_ctrl[5]`=1 leaves it set. While the alarm is set, timing is frozen and no further reset pulse is produced.
- R7: While the alarm is set, `eff_code` equals the safe code `wd_ctrl[4:0]` and `div_sel` is 0.
- R8: Outside the alarm state, `fsel_reg[3]`=0 gives `eff_code` = {0, `strap_fs[3:0]`}. `fsel_reg[3]`=1 gives `eff_code` = {`fsel_reg[2]`, `fsel_reg[7:4]`}.
- R9: Outside the alarm state, `div_sel` follows `wd_ctrl[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 4 | Frequency code latched from strap pins |
| fsel_reg | input | 8 | Frequency-select register: bit 3 picks the source, bits 2 and 7:4 hold the code |
| wd_ctrl | input | 8 | Control register: bit 7 picks divider mode, bit 6 enables, bit 5 is the status write value, bits 4:0 hold the safe code |
| wd_limit | input | 8 | Timeout length in ticks |
| ctrl_wr | input | 1 | One-cycle strobe marking a write of `wd_ctrl`; it restarts timing and may clear the alarm |
| cfg_wr | input | 1 | One-cycle strobe marking any other completed configuration write; it restarts timing |
| eff_code | output | 5 | Frequency-select code in effect |
| div_sel | output | 1 | 1 = take dividers from the direct divider registers |
| sys_rst_n | output | 1 | Active-low system reset pulse raised on timeout |
| wd_alarm | output | 1 | Sticky alarm status |

## Verification
The assertions assume that the strobes `ctrl_wr` and `cfg_wr` last one cycle and that every register input changes only between clock edges. They also assume that a clearing write never arrives on the same edge as an expiry. That assumption holds because any write is a restart, and a restart cancels the tick in that cycle. The stimulus drives all inputs on the falling edge and pulses each strobe for exactly one cycle. It changes `wd_limit` only while no count is running toward the limit in question.

// File: rtl/ocwd_pkg.sv
`timescale 1ns/1ps
package ocwd_pkg;
  localparam int CODE_W = 5;
  localparam int REG_W  = 8;

  // control register fields
  localparam int CTRL_DIV_BIT  = 7;
  localparam int CTRL_EN_BIT   = 6;
  localparam int CTRL_STAT_BIT = 5;

  // frequency-select register fields
  localparam int FSEL_SRC_BIT  = 3;
  localparam int FSEL_MSB_BIT  = 2;

  typedef logic [CODE_W-1:0] fcode_t;

  typedef enum logic [1:0] {
    SRC_STRAP = 2'd0,
    SRC_REG   = 2'd1,
    SRC_SAFE  = 2'd2
  } code_src_t;

  // register code: top bit from bit 2, low four from bits 7:4
  function automatic fcode_t reg_code(input logic [REG_W-1:0] f);
    return {f[FSEL_MSB_BIT], f[7:4]};
  endfunction
endpackage

// File: rtl/ocwd_tick.sv
`timescale 1ns/1ps
module ocwd_tick #(
  parameter int TICK_DIV = 14_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_cnt;

  assign tick = !hold && (pre_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (hold)   pre_cnt <= '0;
    else if (tick)   pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  a_r2_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= LAST);

  a_r3_prescale_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> pre_cnt == '0);
endmodule

// File: rtl/ocwd_timer.sv
`timescale 1ns/1ps
module ocwd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] lim_eff;
  logic [CNT_W:0]   next_cnt;

  assign lim_eff  = (limit == '0) ? CNT_W'(1) : limit;
  assign next_cnt = {1'b0, tick_cnt} + (CNT_W+1)'(1);
  assign expire   = !hold && tick && (next_cnt >= {1'b0, lim_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tick_cnt <= '0;
    else if (hold)   tick_cnt <= '0;
    else if (expire) tick_cnt <= '0;
    else if (tick)   tick_cnt <= tick_cnt + 1'b1;
  end

  a_r2_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(limit) && !hold |-> tick_cnt < lim_eff);

  a_r3_no_expire_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> tick_cnt == '0);
endmodule

// File: rtl/ocwd_alarm.sv
`timescale 1ns/1ps
module ocwd_alarm #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic alarm,
  output logic sys_rst_n
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0] PULSE = RW'(RST_CYCLES);

  logic [RW-1:0] rst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alarm <= 1'b0;
    else if (expire)  alarm <= 1'b1;
    else if (clr_req) alarm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rst_cnt <= '0;
    else if (expire)         rst_cnt <= PULSE;
    else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
  end

  assign sys_rst_n = (rst_cnt == '0);

  a_r5_reset_with_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> !sys_rst_n);

  a_r5_reset_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> $rose(alarm));

  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm && !clr_req |=> alarm);
endmodule

// File: rtl/ocwd_select.sv
`timescale 1ns/1ps
module ocwd_select
  import ocwd_pkg::*;
#(
  parameter int STRAP_W = 4
) (
  input  logic [STRAP_W-1:0] strap,
  input  logic [REG_W-1:0]   fsel,
  input  fcode_t             safe,
  input  logic               div_req,
  input  logic               alarm,
  output fcode_t             code,
  output logic               div_sel
);
  fcode_t    strap_code;
  code_src_t src;
  logic      unused_fsel;

  generate
    if (STRAP_W >= CODE_W) begin : g_trunc
      assign strap_code = strap[CODE_W-1:0];
    end else begin : g_pad
      assign strap_code = {{(CODE_W-STRAP_W){1'b0}}, strap};
    end
  endgenerate

  assign unused_fsel = ^fsel[1:0];

  always_comb begin
    if (alarm)                  src = SRC_SAFE;
    else if (fsel[FSEL_SRC_BIT]) src = SRC_REG;
    else                        src = SRC_STRAP;
  end

  always_comb begin
    unique case (src)
      SRC_SAFE: code = safe;
      SRC_REG:  code = reg_code(fsel);
      default:  code = strap_code;
    endcase
  end

  assign div_sel = div_req && !alarm;
endmodule

// File: rtl/ocwd_top.sv
`timescale 1ns/1ps
module ocwd_top
  import ocwd_pkg::*;
#(
  parameter int TICK_DIV   = 14_500_000,
  parameter int RST_CYCLES = 64,
  parameter int CNT_W      = 8,
  parameter int STRAP_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_fs,
  input  logic [REG_W-1:0]   fsel_reg,
  input  logic [REG_W-1:0]   wd_ctrl,
  input  logic [CNT_W-1:0]   wd_limit,
  input  logic               ctrl_wr,
  input  logic               cfg_wr,
  output logic [CODE_W-1:0]  eff_code,
  output logic               div_sel,
  output logic               sys_rst_n,
  output logic               wd_alarm
);
  logic hold;
  logic tick;
  logic expire;
  logic clr_req;
  fcode_t safe_code;

  assign safe_code = wd_ctrl[CODE_W-1:0];
  assign clr_req   = ctrl_wr && !wd_ctrl[CTRL_STAT_BIT];
  assign hold      = !wd_ctrl[CTRL_EN_BIT] || wd_alarm || ctrl_wr || cfg_wr;

  ocwd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .tick  (tick)
  );

  ocwd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .tick   (tick),
    .limit  (wd_limit),
    .expire (expire)
  );

  ocwd_alarm #(.RST_CYCLES(RST_CYCLES)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .clr_req   (clr_req),
    .alarm     (wd_alarm),
    .sys_rst_n (sys_rst_n)
  );

  ocwd_select #(.STRAP_W(STRAP_W)) u_sel (
    .strap   (strap_fs),
    .fsel    (fsel_reg),
    .safe    (safe_code),
    .div_req (wd_ctrl[CTRL_DIV_BIT]),
    .alarm   (wd_alarm),
    .code    (eff_code),
    .div_sel (div_sel)
  );

  a_r6_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  a_r7_safe_override: assert property (@(posedge clk) disable iff (!rst_n)
    wd_alarm |-> (eff_code == safe_code) && !div_sel);

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_ctrl[CTRL_EN_BIT] && !wd_alarm |=> !wd_alarm);
endmodule

// File: tb/ocwd_top_bench.sv
`timescale 1ns/1ps
module ocwd_top_bench;
  localparam int DIV  = 10;
  localparam int RSTC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap_fs = '0;
  logic [7:0] fsel_reg = '0;
  logic [7:0] wd_ctrl = '0;
  logic [7:0] wd_limit = 8'd1;
  logic       ctrl_wr = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] eff_code;
  logic       div_sel;
  logic       sys_rst_n;
  logic       wd_alarm;

  ocwd_top #(.TICK_DIV(DIV), .RST_CYCLES(RSTC)) u_ocwd_top (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .fsel_reg(fsel_reg),
    .wd_ctrl(wd_ctrl), .wd_limit(wd_limit), .ctrl_wr(ctrl_wr), .cfg_wr(cfg_wr),
    .eff_code(eff_code), .div_sel(div_sel), .sys_rst_n(sys_rst_n), .wd_alarm(wd_alarm)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit done = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor: each alarm rise is matched against the queue
  logic prev_alarm = 1'b0;
  always @(negedge clk) begin
    if (rst_n && wd_alarm && !prev_alarm) begin
      if (exp_q.size() == 0) chk("R6 unexpected alarm at cycle", cyc, -1);
      else                   chk("R2 alarm cycle", cyc, exp_q.pop_front());
    end
    prev_alarm <= wd_alarm;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobe; k is the cycle count seen before the capturing edge
  task automatic pulse(input bit is_ctrl, output int k);
    k = cyc;
    if (is_ctrl) ctrl_wr = 1'b1; else cfg_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    cfg_wr  = 1'b0;
  endtask

  task automatic wait_alarm();
    int guard = 0;
    while (!wd_alarm && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int k;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 alarm after reset", wd_alarm, 0);
    chk("R1 sys_rst_n after reset", sys_rst_n, 1);

    // R8 source selection
    strap_fs = 4'b1010;
    step(1);
    chk("R8 strap path code", eff_code, 5'b01010);
    fsel_reg = 8'b0110_1100;
    step(1);
    chk("R8 register path code", eff_code, 5'b10110);
    // R9 divider mode follows control bit 7
    wd_ctrl = 8'h93;
    step(1);
    chk("R9 div_sel high", div_sel, 1);
    wd_ctrl = 8'h13;
    step(1);
    chk("R9 div_sel low", div_sel, 0);

    // R3 disabled: long wait, nothing happens
    wd_limit = 8'd1;
    pulse(1'b0, k);
    step(100);
    chk("R3 alarm while disabled", wd_alarm, 0);
    chk("R3 sys_rst_n while disabled", sys_rst_n, 1);

    // R2 / R5 / R7 timeout with limit 3
    wd_limit = 8'd3;
    wd_ctrl  = 8'hD3;
    pulse(1'b0, k);
    exp_q.push_back(k + 1 + 3 * DIV);
    wait_alarm();
    chk("R5 reset low on alarm edge", sys_rst_n, 0);
    chk("R7 safe code in alarm", eff_code, 5'b10011);
    chk("R7 div_sel forced low", div_sel, 0);
    step(RSTC - 1);
    chk("R5 reset still low at last pulse cycle", sys_rst_n, 0);
    step(1);
    chk("R5 reset released", sys_rst_n, 1);

    // R6 writing status 1 keeps alarm; no new pulse while alarmed
    wd_ctrl = 8'hF3;
    pulse(1'b1, k);
    step(50);
    chk("R6 alarm kept by status-1 write", wd_alarm, 1);
    chk("R6 no second reset pulse", sys_rst_n, 1);

    // R6 clear, and R2 with limit 0 treated as one tick
    wd_limit = 8'd0;
    wd_ctrl  = 8'hD3;
    pulse(1'b1, k);
    exp_q.push_back(k + 1 + DIV);
    chk("R6 alarm cleared by status-0 write", wd_alarm, 0);
    chk("R8 code back to register path", eff_code, 5'b10110);
    wait_alarm();
    chk("R2 alarm after limit-0 timeout", wd_alarm, 1);

    // R4 restart part way through a limit-2 count
    wd_limit = 8'd2;
    wd_ctrl  = 8'h53;
    pulse(1'b1, k);
    step(15);
    chk("R4 no alarm before restart", wd_alarm, 0);
    pulse(1'b0, k);
    exp_q.push_back(k + 1 + 2 * DIV);
    wait_alarm();
    chk("R7 safe code after restart timeout", eff_code, 5'b10011);

    // disable and clear: strap path with bit 3 low
    wd_ctrl  = 8'h13;
    fsel_reg = 8'h00;
    pulse(1'b1, k);
    step(30);
    chk("R3 alarm stays clear when disabled", wd_alarm, 0);
    chk("R8 strap code after clear", eff_code, 5'b01010);

    chk("R2 pending expected alarms", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule